// File: doc/BRIEF.md
# Management Register Access Controller

A single 32-bit command/status register sits between a host and an external PHY's management port. One host write that names a read or a write operation starts one clause-22 management frame. The frame is serialised on a divided management clock and a data pin with a separate output enable. The same register then reports completion through a ready bit and, after a read, returns the PHY's 16-bit answer in its low half. An optional completion interrupt saves the host from polling.

The register keeps the fields of the last accepted command, so a read of the register shows the operation, the addresses and the data field. Writes that arrive while a frame is in flight are dropped. A command word with no operation bit set, or with both set, is stored but starts no frame.

Top module: `mgmt_reg_ctrl`

## Requirements
- R1: After reset the register reads 0x1000_0000 (only the ready flag, bit 28, set), `irq` is low, `mdc` is low and `mdio_oe` is low.
- R2: Command word layout: bit 29 is the interrupt enable, bit 27 requests a read, bit 26 requests a write, bits 25:21 are the PHY address, bits 20:16 are the register address and bits 15:0 are the write data. Bits 31:30 read as zero. A read of the register returns the fields of the last accepted command.
- R3: A write that starts a frame clears the ready flag (bit 28), as seen in the cycle after the write.
- R4: Every frame begins with 32 one bits, then the start pair 0,1, then the opcode 1,0 for a read or 0,1 for a write, then the 5-bit PHY address and the 5-bit register address, each sent MSB first.
- R5: In a write frame the turnaround bits 1,0 follow, then the 16 data bits MSB first, and `mdio_oe` stays high for all 64 bit times.
- R6: In a read frame `mdio_oe` is low for the last 18 bit times (turnaround and data). The 16 data bits are sampled from `mdio_in` at the rising edges of `mdc`, MSB first, and land in bits 15:0 at completion.
- R7: `mdc` has a period of 2*CLK_DIV clock cycles and `mdio_out` changes only while `mdc` is low. Ready returns exactly 128*CLK_DIV cycles after the clock edge that accepts the command.
- R8: If bit 29 of the accepted command is set, `irq` rises together with the ready flag. If bit 29 is clear, `irq` stays low. Any write to the register clears `irq`.
- R9: A write while a frame is in flight is ignored: the frame, its timing and the stored fields are those of the earlier command.
- R10: A command with neither or both opcode bits set starts no frame. Ready stays set, `mdc` stays low and `mdio_oe` stays low. The word's fields are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Command word written by the host |
| reg_rdata | output | 32 | Register contents: status, fields, read data |
| irq | output | 1 | Completion interrupt |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the management data pin |
| mdio_in | input | 1 | Management data returned by the PHY |

## Verification
The bench builds the block with CLK_DIV = 2. This keeps a whole frame at 256 cycles, so every opcode and field pattern, a collision with a busy frame and the interrupt clear all fit in a short run. With a ratio above 1, each `mdc` half period spans more than one system cycle. That lets the bench see that the data pin holds through the high phase, and that read data are sampled on the rising edge and not one cycle off. The exact completion count of 256 cycles confirms that the divider and the 64-bit counter are chained without an extra stage.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef struct packed {
    logic [1:0]  rsv;
    logic        ie;
    logic        rdy;
    logic        rd;
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mgmt_word_t;

endpackage

// File: rtl/mgmt_mdc_div.sv
module mgmt_mdc_div #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick = run && (cnt_q == CNT_END);
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R10
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc_q);

endmodule

// File: rtl/mgmt_mdio_frame.sv
module mgmt_mdio_frame
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        mdc,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_in,
  output logic        busy,
  output logic        done,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic [15:0] rx_data
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA_IDX   = BW'(TA_FIRST);
  localparam logic [BW-1:0] DAT_IDX  = BW'(DATA_FIRST);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [15:0]           rx_q, rx_d;

  assign busy     = busy_q;
  assign done     = busy_q && fall && (bit_q == LAST_BIT);
  assign mdio_out = busy_q && sh_q[FRAME_BITS-1];
  assign mdio_oe  = busy_q && !(rd_q && (bit_q >= TA_IDX));
  assign rx_data  = rx_q;

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    rx_d   = rx_q;
    if (start) begin
      sh_d   = {{PRE_BITS{1'b1}}, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, regad,
                2'b10, (is_rd ? 16'h0000 : wdata)};
      bit_d  = '0;
      busy_d = 1'b1;
      rd_d   = is_rd;
    end else if (busy_q) begin
      if (rise && rd_q && (bit_q >= DAT_IDX))
        rx_d = {rx_q[14:0], mdio_in};
      if (fall) begin
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      rx_q   <= rx_d;
    end
  end

  // R7
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mdc && !fall) |=> $stable(mdio_out));

  // R6
  release_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mdio_oe) |-> rd_q);

endmodule

// File: rtl/mgmt_reg_ctrl.sv
module mgmt_reg_ctrl
  import mgmt_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int CYC_LIMIT = 2 * FRAME_BITS * CLK_DIV;
  localparam int CCW       = $clog2(CYC_LIMIT + 1);

  logic [1:0]  rst_sync_q;
  logic        srst_n;
  mgmt_word_t  wr_word;
  mgmt_word_t  cmd_q, cmd_d;
  logic        irq_q, irq_d;
  logic        accept, valid_op;
  logic        busy, done;
  logic        rise, fall;
  logic [15:0] rx_data;
  logic [CCW-1:0] busy_cyc_q, busy_cyc_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  assign wr_word  = mgmt_word_t'(reg_wdata);
  assign accept   = reg_wr && !busy;
  assign valid_op = wr_word.rd ^ wr_word.wr;

  mgmt_mdc_div #(.CLK_DIV(CLK_DIV)) i_div (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (busy),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mgmt_mdio_frame i_frame (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (accept && valid_op),
    .is_rd    (wr_word.rd),
    .phy      (wr_word.phy),
    .regad    (wr_word.regad),
    .wdata    (wr_word.data),
    .mdc      (mdc),
    .rise     (rise),
    .fall     (fall),
    .mdio_in  (mdio_in),
    .busy     (busy),
    .done     (done),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rx_data  (rx_data)
  );

  always_comb begin
    cmd_d = cmd_q;
    irq_d = irq_q;
    if (reg_wr) irq_d = 1'b0;
    if (accept) begin
      cmd_d     = wr_word;
      cmd_d.rsv = 2'b00;
      cmd_d.rdy = !valid_op;
    end else if (done) begin
      cmd_d.rdy = 1'b1;
      if (cmd_q.rd) cmd_d.data = rx_data;
      if (cmd_q.ie) irq_d = 1'b1;
    end
  end

  always_comb begin
    busy_cyc_d = busy_cyc_q;
    if (accept)    busy_cyc_d = '0;
    else if (busy) busy_cyc_d = busy_cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cmd_q      <= '{rsv: 2'b00, ie: 1'b0, rdy: 1'b1, rd: 1'b0, wr: 1'b0,
                      phy: 5'd0, regad: 5'd0, data: 16'h0000};
      irq_q      <= 1'b0;
      busy_cyc_q <= '0;
    end else begin
      cmd_q      <= cmd_d;
      irq_q      <= irq_d;
      busy_cyc_q <= busy_cyc_d;
    end
  end

  assign reg_rdata = cmd_q;
  assign irq       = irq_q;

  // R3
  ready_busy_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_q.rdy != busy);

  // R8
  irq_ready_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq_q |-> cmd_q.rdy);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && reg_wr) |=> $stable({cmd_q.rd, cmd_q.wr, cmd_q.phy, cmd_q.regad, cmd_q.ie}));

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    busy |-> (busy_cyc_q < CCW'(CYC_LIMIT)));

endmodule

// File: tb/test_mgmt_reg_ctrl.sv
`timescale 1ns/1ps
module test_mgmt_reg_ctrl;
  localparam int DIV = 2;
  localparam int NVEC = 5;
  // {command word, data the PHY returns}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h2822_0000, 16'hA5C3},
    {32'h07E0_1234, 16'h0000},
    {32'h081F_0000, 16'h8001},
    {32'h26AA_FFFF, 16'h0000},
    {32'h2955_5555, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, mdc, mdio_out, mdio_oe, mdio_in;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  mgmt_reg_ctrl #(.CLK_DIV(DIV)) i_mgmt_reg_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY model
  logic [63:0] cap = '0;
  int          mdc_cnt = 0;
  int          rel_cnt = 0;
  int          base = 0;
  logic [15:0] phy_word = '0;
  int          rel;

  always @(posedge mdc) begin
    cap     <= {cap[62:0], (mdio_oe ? mdio_out : 1'b1)};
    rel_cnt <= rel_cnt + (mdio_oe ? 0 : 1);
    mdc_cnt <= mdc_cnt + 1;
  end
  assign rel     = mdc_cnt - base;
  assign mdio_in = (rel >= 48 && rel < 64) ? phy_word[63 - rel] : 1'b1;

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write at a negedge; n = cycles from accepting edge to ready seen
  task automatic issue(input logic [31:0] w, input logic [15:0] pd, output int n);
    phy_word  = pd;
    base      = mdc_cnt;
    reg_wdata = w;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    n = 0;
  endtask

  task automatic wait_ready(inout int n);
    while (!reg_rdata[28] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int n, rel0, mc0;
    logic [31:0] w, expw;
    logic [15:0] pd;
    logic        isrd;
    logic [63:0] expf;

    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(reg_rdata == 32'h1000_0000, "R1 reset word", reg_rdata, 32'h1000_0000);
    chk({irq, mdc, mdio_oe} == 3'b000, "R1 reset pins", {irq, mdc, mdio_oe}, 0);

    for (int i = 0; i < NVEC; i++) begin
      w    = VEC[i][47:16];
      pd   = VEC[i][15:0];
      isrd = w[27];
      rel0 = rel_cnt;
      issue(w, pd, n);
      // R3
      chk(reg_rdata[28] == 1'b0, "R3 ready cleared", reg_rdata[28], 0);
      wait_ready(n);
      // R7
      chk(n == 128 * DIV, "R7 completion cycles", n, 128 * DIV);
      expf = {32'hFFFF_FFFF, 2'b01, (isrd ? 2'b10 : 2'b01), w[25:21], w[20:16],
              (isrd ? 18'h3FFFF : {2'b10, w[15:0]})};
      // R4 R5
      chk(cap == expf, isrd ? "R4 read frame" : "R5 write frame", cap, expf);
      // R6 R5
      chk(rel_cnt - rel0 == (isrd ? 18 : 0), isrd ? "R6 release" : "R5 driven",
          rel_cnt - rel0, isrd ? 18 : 0);
      expw = {2'b00, w[29], 1'b1, w[27:16], (isrd ? pd : w[15:0])};
      // R2 R6
      chk(reg_rdata == expw, "R2 R6 readback", reg_rdata, expw);
      // R8
      chk(irq == w[29], "R8 irq on done", irq, w[29]);
    end

    // R8: any write clears irq (last vector had ie set)
    issue(32'h0000_ABCD, 16'h0, n);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
    // R10 neither opcode bit
    chk(reg_rdata == 32'h1000_ABCD, "R10 no-op stored", reg_rdata, 32'h1000_ABCD);
    mc0 = mdc_cnt;
    // R10 both opcode bits
    issue(32'h0C00_0000, 16'h0, n);
    chk(reg_rdata == 32'h1C00_0000, "R10 both ops ready", reg_rdata, 32'h1C00_0000);
    repeat (20) @(negedge clk);
    chk(mdc_cnt == mc0 && !mdio_oe && !mdc, "R10 no frame", mdc_cnt - mc0, 0);

    // R9 write while busy
    issue(32'h0462_BEEF, 16'h0, n);
    repeat (50) @(negedge clk);
    n += 50;
    reg_wdata = 32'h2BFF_0000;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    n++;
    wait_ready(n);
    chk(n == 128 * DIV, "R9 timing kept", n, 128 * DIV);
    expf = {32'hFFFF_FFFF, 4'b0101, 5'd3, 5'd2, 2'b10, 16'hBEEF};
    chk(cap == expf, "R9 frame kept", cap, expf);
    chk(reg_rdata == 32'h1462_BEEF, "R9 fields kept", reg_rdata, 32'h1462_BEEF);
    chk(irq == 1'b0, "R9 no irq", irq, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule